// File: doc/BRIEF.md
# Command List Register Writer

This block turns a stream of 32-bit command-list words into writes to a local register file. Software or a fetch engine pulses `start` together with the list length in words, then feeds the words over a valid/ready handshake. Each command is a data word followed by a header word. The header names a target register, a four-lane byte-enable, a count of extra data words that follow, and a flag. The flag chooses whether the extra words all land on the header's register or walk upward through consecutive registers.

Every write merges the new word into the stored value through the expanded byte mask. The block shows the stored result on a registered write port, one cycle after the word that caused it. A designated trigger register raises a one-cycle interrupt pulse when it is written. A frame-skip input blocks every write except those to the trigger register. Writes aimed past the end of the register file are dropped. Each new command starts on an even word offset from the list start, so an odd leftover word is skipped as padding. Parsing stops as soon as the programmed number of words has been consumed, even in the middle of a command. A done pulse marks that point.

Top module: `cmdw_top`

## Requirements
- R1: A command is a data word followed by a header word. The header layout is register id in bits [15:0], lane mask in [19:16], extra-word count in [27:20] and the walk flag in bit 31. The data word is written to the header's id. The write appears on `wr_strobe`/`wr_id`/`wr_data` in the cycle after the header is accepted.
- R2: Mask bit i enables byte lane i, which is data bits [8i+7:8i]. The stored value becomes (old & ~m) | (new & m), and `wr_data` shows that stored value. A mask of zero still produces a strobe, carrying the unchanged contents.
- R3: The number of extra words given by the count follows the header. With the walk flag set, extra word k (counting from 1) goes to id+k. With it clear, every extra word goes to the header id.
- R4: Every extra write uses the header's lane mask.
- R5: Before each command, if the number of words consumed since the list start is odd, one word is consumed and discarded.
- R6: A write to an id at or above NUM_REGS produces no strobe and changes no register.
- R7: While `frame_skip` is high when a write is accepted, only writes to id TRIG_ID take effect. Other writes produce no strobe and change no register.
- R8: A write that takes effect on id TRIG_ID raises `irq` for one cycle, in the same cycle as its strobe, whether or not frame-skip is set.
- R9: Once the word count reaches the programmed length, `in_ready` goes low and stays low until the next start. `done` pulses exactly once. A command cut off by the length performs only the writes whose words were consumed.
- R10: After reset every register holds zero, and `in_ready`, `wr_strobe`, `irq` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a list when the block is idle |
| list_len | input | LEN_W | List length in words, sampled with start |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted when high with in_valid |
| in_data | input | 32 | Stream word |
| frame_skip | input | 1 | Blocks all writes except those to the trigger register |
| wr_strobe | output | 1 | A register write took effect |
| wr_id | output | 16 | Register id of that write |
| wr_data | output | 32 | Merged value now stored in that register |
| irq | output | 1 | One-cycle pulse on a trigger-register write |
| done | output | 1 | One-cycle pulse when the list length is reached |

## Verification
Register contents are only visible through the merged value on the write port. A corrupted storage word therefore stays hidden until that register is written again. A later mask-zero write exposes it at once, and the sweeps use such writes to read back registers after dropped or skipped writes. A wrong parser state or position shows up on the very next handshake. A misplaced padding skip or a miscounted extra word shifts every later word between data and header roles, so the following strobe carries a wrong id or value, or an unexpected strobe appears. A length counter that is off by one shows up as a missing or extra strobe and a done pulse one cycle early or late.

// File: rtl/cmdw_pkg.sv
`timescale 1ns/1ps
package cmdw_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int ID_W   = 16;
    localparam int CNT_W  = 8;

    // Header word as seen on the stream
    typedef struct packed {
        logic             walk;
        logic [2:0]       spare;
        logic [CNT_W-1:0] extra;
        logic [LANES-1:0] lanes;
        logic [ID_W-1:0]  id;
    } cmd_hdr_t;

    // One register write request from the parser
    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  lanes;
    } wreq_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_HDR,
        ST_EXTRA
    } parse_st_t;

    function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] l);
        logic [WORD_W-1:0] m;
        for (int b = 0; b < LANES; b++) begin
            m[8*b +: 8] = {8{l[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/cmdw_parser.sv
`timescale 1ns/1ps
module cmdw_parser
    import cmdw_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  list_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              req_valid,
    output wreq_t             req,
    output logic              done
);

    parse_st_t         state;
    logic [LEN_W-1:0]  pos;
    logic [LEN_W-1:0]  len_q;
    logic [WORD_W-1:0] data0;
    logic [ID_W-1:0]   cur_id;
    logic [LANES-1:0]  lanes_q;
    logic              walk_q;
    logic [CNT_W-1:0]  remain;

    logic              busy;
    logic              at_end;
    logic              take;
    cmd_hdr_t          hdr;
    logic [ID_W-1:0]   next_id;

    always_comb begin
        busy      = (state != ST_IDLE);
        at_end    = (pos == len_q);
        in_ready  = busy && !at_end;
        take      = in_valid && in_ready;
        hdr       = cmd_hdr_t'(in_data);
        next_id   = walk_q ? cur_id + 1'b1 : cur_id;
        req_valid = take && (state == ST_HDR || state == ST_EXTRA);
        if (state == ST_HDR) begin
            req.id    = hdr.id;
            req.data  = data0;
            req.lanes = hdr.lanes;
        end else begin
            req.id    = next_id;
            req.data  = in_data;
            req.lanes = lanes_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pos     <= '0;
            len_q   <= '0;
            data0   <= '0;
            cur_id  <= '0;
            lanes_q <= '0;
            walk_q  <= 1'b0;
            remain  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    pos   <= '0;
                    len_q <= list_len;
                    state <= ST_DATA;
                end
            end else if (at_end) begin
                state <= ST_IDLE;
                done  <= 1'b1;
            end else if (take) begin
                pos <= pos + 1'b1;
                case (state)
                    ST_DATA: begin
                        // odd offset: this word is padding
                        if (!pos[0]) begin
                            data0 <= in_data;
                            state <= ST_HDR;
                        end
                    end
                    ST_HDR: begin
                        cur_id  <= hdr.id;
                        lanes_q <= hdr.lanes;
                        walk_q  <= hdr.walk;
                        remain  <= hdr.extra;
                        state   <= (hdr.extra == '0) ? ST_DATA : ST_EXTRA;
                    end
                    ST_EXTRA: begin
                        cur_id <= next_id;
                        remain <= remain - 1'b1;
                        if (remain == CNT_W'(1)) state <= ST_DATA;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !in_ready);

    assert_len_bound_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pos <= len_q));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_pad_skip_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && take && pos[0]) |=> (state == ST_DATA));

endmodule

// File: rtl/cmdw_gate.sv
`timescale 1ns/1ps
module cmdw_gate
    import cmdw_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int TRIG_ID  = 16
) (
    input  logic            req_valid,
    input  logic [ID_W-1:0] req_id,
    input  logic            frame_skip,
    output logic            accept,
    output logic            is_trig
);

    localparam logic [31:0] LIMIT = 32'(NUM_REGS);

    logic in_range;

    always_comb begin
        in_range = (32'(req_id) < LIMIT);
        is_trig  = (req_id == ID_W'(TRIG_ID));
        accept   = req_valid && in_range && (!frame_skip || is_trig);
    end

endmodule

// File: rtl/cmdw_regfile.sv
`timescale 1ns/1ps
module cmdw_regfile
    import cmdw_pkg::*;
#(
    parameter int NUM_REGS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wreq_t             req,
    input  logic              is_trig,
    output logic              wr_strobe,
    output logic [ID_W-1:0]   wr_id,
    output logic [WORD_W-1:0] wr_data,
    output logic              irq
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [WORD_W-1:0] mem [NUM_REGS];
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] m;
    logic [WORD_W-1:0] merged;

    always_comb begin
        idx    = req.id[IDX_W-1:0];
        m      = lane_mask(req.lanes);
        merged = (mem[idx] & ~m) | (req.data & m);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
            wr_strobe <= 1'b0;
            wr_id     <= '0;
            wr_data   <= '0;
            irq       <= 1'b0;
        end else begin
            wr_strobe <= wr_en;
            irq       <= wr_en && is_trig;
            if (wr_en) begin
                mem[idx] <= merged;
                wr_id    <= req.id;
                wr_data  <= merged;
            end
        end
    end

    assert_range_R6: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (32'(wr_id) < 32'(NUM_REGS)));

endmodule

// File: rtl/cmdw_top.sv
`timescale 1ns/1ps
module cmdw_top
    import cmdw_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int TRIG_ID  = 16,
    parameter int LEN_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  list_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              frame_skip,
    output logic              wr_strobe,
    output logic [ID_W-1:0]   wr_id,
    output logic [WORD_W-1:0] wr_data,
    output logic              irq,
    output logic              done
);

    logic  req_valid;
    wreq_t req;
    logic  accept;
    logic  is_trig;

    cmdw_parser #(.LEN_W(LEN_W)) u_parser (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .list_len  (list_len),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .req_valid (req_valid),
        .req       (req),
        .done      (done)
    );

    cmdw_gate #(.NUM_REGS(NUM_REGS), .TRIG_ID(TRIG_ID)) u_gate (
        .req_valid  (req_valid),
        .req_id     (req.id),
        .frame_skip (frame_skip),
        .accept     (accept),
        .is_trig    (is_trig)
    );

    cmdw_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept),
        .req       (req),
        .is_trig   (is_trig),
        .wr_strobe (wr_strobe),
        .wr_id     (wr_id),
        .wr_data   (wr_data),
        .irq       (irq)
    );

    assert_skip_only_trig_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && $past(frame_skip)) |-> (wr_id == ID_W'(TRIG_ID)));

    assert_irq_with_write_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (wr_strobe && wr_id == ID_W'(TRIG_ID)));

    assert_write_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> $past(req_valid));

endmodule

// File: tb/cmdw_top_bench.sv
`timescale 1ns/1ps
module cmdw_top_bench;

    localparam int NREG = 64;
    localparam int TRIG = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] list_len = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        frame_skip = 1'b0;
    logic        wr_strobe;
    logic [15:0] wr_id;
    logic [31:0] wr_data;
    logic        irq;
    logic        done;

    always #4 clk = ~clk;

    cmdw_top #(.NUM_REGS(NREG), .TRIG_ID(TRIG), .LEN_W(16)) u_cmdw_top (
        .clk(clk), .rst(rst), .start(start), .list_len(list_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .frame_skip(frame_skip), .wr_strobe(wr_strobe), .wr_id(wr_id),
        .wr_data(wr_data), .irq(irq), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int done_seen = 0;
    string tag = "R10";

    logic [31:0] lst[$];
    logic [31:0] ref_mem[NREG];
    logic [15:0] eq_id[$];
    logic [31:0] eq_data[$];
    logic        eq_irq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] ln,
                                        input int extra, input bit walk);
        return {walk, 3'b000, 8'(extra), ln, id};
    endfunction

    // Start each command on an even offset with a junk padding word
    task automatic cmd(input logic [31:0] d, input logic [15:0] id, input logic [3:0] ln,
                       input int extra, input bit walk);
        if (lst.size() % 2 == 1) lst.push_back(32'hBAD0_0000 | 32'(lst.size()));
        lst.push_back(d);
        lst.push_back(hdr(id, ln, extra, walk));
        for (int k = 1; k <= extra; k++) lst.push_back(d ^ (32'h1111_1111 * 32'(k)));
    endtask

    task automatic mwrite(input logic [15:0] id, input logic [31:0] d, input logic [3:0] ln);
        logic [31:0] m;
        if (32'(id) >= NREG) return;
        if (frame_skip && id != 16'(TRIG)) return;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{ln[b]}};
        ref_mem[id[5:0]] = (ref_mem[id[5:0]] & ~m) | (d & m);
        eq_id.push_back(id);
        eq_data.push_back(ref_mem[id[5:0]]);
        eq_irq.push_back(id == 16'(TRIG));
    endtask

    task automatic model(input int len);
        int p = 0;
        logic [31:0] d, h;
        while (p < len) begin
            if (p % 2 == 1) begin p++; continue; end
            d = lst[p]; p++;
            if (p >= len) break;
            h = lst[p]; p++;
            mwrite(h[15:0], d, h[19:16]);
            for (int k = 1; k <= int'(h[27:20]); k++) begin
                if (p >= len) break;
                mwrite(h[31] ? h[15:0] + 16'(k) : h[15:0], lst[p], h[19:16]);
                p++;
            end
        end
    endtask

    task automatic run(input int len);
        int d0;
        bit ok;
        model(len);
        d0 = done_seen;
        @(negedge clk);
        start = 1'b1; list_len = 16'(len);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (i % 5 == 3) begin in_valid = 1'b0; @(negedge clk); end
            in_valid = 1'b1; in_data = lst[i];
            forever begin
                #3; ok = in_ready;
                @(negedge clk);
                if (ok) break;
            end
        end
        in_valid = 1'b1; in_data = 32'hFFFF_FFFF;
        for (int w = 0; w < 10 && done_seen == d0; w++) @(negedge clk);
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            chk(!in_ready, "R9", "ready after end", {31'b0, in_ready}, 32'd0);
        end
        in_valid = 1'b0;
        chk(done_seen - d0 == 1, "R9", "done pulses", 32'(done_seen - d0), 32'd1);
        chk(eq_id.size() == 0, tag, "missing writes", 32'(eq_id.size()), 32'd0);
        eq_id.delete(); eq_data.delete(); eq_irq.delete();
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_seen++;
            if (wr_strobe) begin
                if (eq_id.size() == 0) begin
                    chk(1'b0, tag, "unexpected write id", {16'b0, wr_id}, 32'hFFFF_FFFF);
                end else begin
                    chk(wr_id == eq_id[0], tag, "write id", {16'b0, wr_id}, {16'b0, eq_id[0]});
                    chk(wr_data == eq_data[0], tag, "write data", wr_data, eq_data[0]);
                    chk(irq == eq_irq[0], "R8", "irq", {31'b0, irq}, {31'b0, eq_irq[0]});
                    void'(eq_id.pop_front()); void'(eq_data.pop_front()); void'(eq_irq.pop_front());
                end
            end else if (irq) begin
                chk(1'b0, "R8", "irq without write", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        #(8 * 150000);
        chk(1'b0, "ALL", "watchdog", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: quiet outputs after reset
        chk(!in_ready, "R10", "in_ready", {31'b0, in_ready}, 32'd0);
        chk(!wr_strobe, "R10", "wr_strobe", {31'b0, wr_strobe}, 32'd0);
        chk(!irq && !done, "R10", "irq/done", {30'b0, irq, done}, 32'd0);

        // R1/R2/R10: every lane mask on one register, starting from zero
        tag = "R2";
        lst.delete();
        for (int m = 0; m < 16; m++) cmd(32'hA1B2C3D4 ^ (32'h0101_0101 * 32'(m)), 16'd3, 4'(m), 0, 1'b0);
        run(lst.size());

        // R3/R4/R5: extra counts, both walk modes, odd counts force padding
        tag = "R3";
        for (int w = 0; w < 2; w++) begin
            lst.delete();
            for (int c = 0; c < 5; c++) cmd(32'h5A00_0000 + 32'(c * 16 + w), 16'(8 + c * 6), 4'(c + 9), c, w[0]);
            run(lst.size());
        end
        tag = "R4";
        lst.delete();
        cmd(32'hCAFE_F00D, 16'd50, 4'b0101, 3, 1'b1);
        cmd(32'h1234_5678, 16'd50, 4'b1010, 2, 1'b0);
        run(lst.size());

        // R6: out-of-range ids, walk across the top, then read back by mask-zero writes
        tag = "R6";
        lst.delete();
        cmd(32'h0F0F_0F0F, 16'd63, 4'hF, 0, 1'b0);
        cmd(32'h7777_7777, 16'd64, 4'hF, 0, 1'b0);
        cmd(32'h6666_6666, 16'd100, 4'hF, 1, 1'b0);
        cmd(32'h5555_5555, 16'hFFF0, 4'hF, 0, 1'b0);
        cmd(32'h4444_4444, 16'd62, 4'hF, 3, 1'b1);
        cmd(32'h0, 16'd0, 4'h0, 0, 1'b0);
        cmd(32'h0, 16'd36, 4'h0, 0, 1'b0);
        cmd(32'h0, 16'd1, 4'h0, 1, 1'b1);
        run(lst.size());

        // R7/R8: frame skip lets only the trigger register through
        tag = "R7";
        frame_skip = 1'b1;
        lst.delete();
        cmd(32'h9999_0001, 16'd5, 4'hF, 0, 1'b0);
        cmd(32'h9999_0002, 16'd16, 4'hF, 0, 1'b0);
        cmd(32'h9999_0003, 16'd14, 4'hF, 3, 1'b1);
        cmd(32'h9999_0004, 16'd16, 4'h3, 1, 1'b0);
        run(lst.size());
        frame_skip = 1'b0;
        tag = "R8";
        lst.delete();
        cmd(32'h0, 16'd5, 4'h0, 0, 1'b0);
        cmd(32'h0, 16'd14, 4'h0, 3, 1'b1);
        cmd(32'h2468_ACE0, 16'd16, 4'hC, 0, 1'b0);
        run(lst.size());

        // R9: cut the list at every length through two commands
        tag = "R9";
        lst.delete();
        cmd(32'h3C3C_0000, 16'd40, 4'hF, 3, 1'b1);
        cmd(32'h00C3_C3C3, 16'd41, 4'h6, 2, 1'b0);
        for (int len = 0; len <= lst.size(); len++) run(len);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule